// File: doc/BRIEF.md
# Byte-lane asynchronous SRAM model

This block is a synthesizable model of an asynchronous static memory with a data word built from byte lanes. Its size is set by parameters. A fast system clock samples the memory pins. The chip-select pins, the write strobe, the output-drive control and one active-low enable per lane are decoded into four modes: powered down, read, write and selected-but-quiet. The bidirectional data bus is split into three ports: `wdata` carries the data in, `rdata` carries the data out, and `rdata_oe` is a drive enable with one bit per lane. A surrounding tri-state pad or bus model combines them.

For each lane, a write window is open while the device is selected, the write strobe is low and that lane's enable is low. The window closes when any one of those conditions ends. In the clock cycle in which the model sees the window closed, it stores the last data sampled while the window was open into that lane. Lanes outside the window keep their contents. Reads are combinational from the live address and lane enables, so access takes zero cycles, and only lanes whose enable is low are driven. A parameter chooses between a pair of chip selects of opposite polarity and a single active-low select.

Top module: `bl_async_sram`

## Requirements
- R1: With `DUAL_SEL=1` the device is selected only when `sel_n`=0 and `sel_p`=1. While it is deselected no lane is driven (`rdata_oe`=0) and no write is stored, whatever the other pins do.
- R2: With `DUAL_SEL=0` only `sel_n`=0 selects the device and `sel_p` has no effect. Reads and writes then behave the same with `sel_p`=0 as with `sel_p`=1.
- R3: A write takes place when the device is selected and `wr_n`=0. The value of `drv_n` during the write has no effect on what is stored.
- R4: A write stores `wdata[7:0]` only when `lane_n[0]`=0 and stores `wdata[15:8]` only when `lane_n[1]`=0. A lane whose enable stays high keeps its previous contents.
- R5: A read (selected, `drv_n`=0, `wr_n`=1) sets `rdata_oe[i]`=1 exactly for the lanes with `lane_n[i]`=0. Those lanes show the stored byte at `addr` in the same cycle.
- R6: A lane is not driven (`rdata_oe[i]`=0) while any write is in progress, when `drv_n`=1, or when its own `lane_n[i]`=1. `rdata` bits of a lane that is not driven read as 0.
- R7: When the device is selected with `drv_n`=1 and `wr_n`=1, it drives no lane and changes no stored data, even if the lane enables are low and `wdata` changes.
- R8: A lane's write window closes when `wr_n` rises, when the device is deselected, or when that lane's enable rises, whichever happens first. The byte stored is the last one sampled while that lane's window was open. A change of `wdata` in the closing cycle is ignored, and one lane can close before the other.
- R9: While `rst_n`=0 and with the pins idle, `rdata_oe` is 0. Releasing reset stores nothing.
- R10: Stored data appears at `rdata` from the first clock edge at which the closed window is sampled. This allows a read one clock cycle after the closing pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low chip select |
| sel_p | input | 1 | Active-high chip select (used only when DUAL_SEL=1) |
| wr_n | input | 1 | Active-low write strobe |
| drv_n | input | 1 | Active-low output drive control |
| lane_n | input | LANES | Active-low byte-lane enables, bit 0 = lowest byte |
| addr | input | AW | Word address |
| wdata | input | LANES*LW | Data in from the bus |
| rdata | output | LANES*LW | Data out toward the bus, 0 on lanes not driven |
| rdata_oe | output | LANES | Per-lane drive enable for the bus |

## Verification
The assertions assume that the pins change away from the rising clock edge, so that every sampled value is stable. They also assume that a written address is held for at least one sampled cycle of an open window. The bench changes every pin only on the falling edge and holds each phase of a write for whole clock periods. It then closes the window in each of the three ways, while putting a different value on `wdata` in the closing cycle. Both select variants share the same pins, so each chip-select combination tests both variants against their own reference memories.

// File: rtl/bl_sram_pkg.sv
package bl_sram_pkg;
  typedef enum logic [1:0] {
    MD_OFF   = 2'd0,
    MD_READ  = 2'd1,
    MD_WRITE = 2'd2,
    MD_QUIET = 2'd3
  } sram_mode_e;
endpackage

// File: rtl/bl_sram_decode.sv
module bl_sram_decode
  import bl_sram_pkg::*;
#(
  parameter int DUAL_SEL = 1,
  parameter int LANES    = 2
) (
  input  logic             sel_n,
  input  logic             sel_p,
  input  logic             wr_n,
  input  logic             drv_n,
  input  logic [LANES-1:0] lane_n,
  output sram_mode_e       mode,
  output logic [LANES-1:0] drv_lane,
  output logic [LANES-1:0] win_lane
);
  logic selected;

  always_comb begin
    selected = ~sel_n & ((DUAL_SEL != 0) ? sel_p : 1'b1);
    if (!selected)  mode = MD_OFF;
    else if (!wr_n) mode = MD_WRITE;
    else if (!drv_n) mode = MD_READ;
    else            mode = MD_QUIET;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign drv_lane[i] = (mode == MD_READ)  & ~lane_n[i];
    assign win_lane[i] = (mode == MD_WRITE) & ~lane_n[i];
  end
endmodule

// File: rtl/bl_sram_wctl.sv
module bl_sram_wctl #(
  parameter int AW    = 10,
  parameter int LANES = 2,
  parameter int LW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LANES-1:0]    win_lane,
  input  logic [AW-1:0]       addr,
  input  logic [LANES*LW-1:0] wdata,
  output logic [LANES-1:0]    commit,
  output logic [AW-1:0]       c_addr,
  output logic [LANES*LW-1:0] c_data
);
  localparam int DW = LANES * LW;

  logic [LANES-1:0] s_win, s_win_d;
  logic [AW-1:0]    s_addr, s_addr_d;
  logic [DW-1:0]    s_data, s_data_d;
  logic             addr_en;

  always_comb begin
    addr_en  = |win_lane;
    s_win_d  = win_lane;
    s_addr_d = addr_en ? addr : s_addr;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      s_data_d[i*LW +: LW] = win_lane[i] ? wdata[i*LW +: LW] : s_data[i*LW +: LW];
    end
    assign commit[i] = s_win[i] & ~win_lane[i];

    // R8
    commit_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit[i] |=> !commit[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_win  <= '0;
      s_addr <= '0;
      s_data <= '0;
    end else begin
      s_win  <= s_win_d;
      s_addr <= s_addr_d;
      s_data <= s_data_d;
    end
  end

  assign c_addr = s_addr;
  assign c_data = s_data;
endmodule

// File: rtl/bl_sram_array.sv
module bl_sram_array #(
  parameter int AW    = 10,
  parameter int LANES = 2,
  parameter int LW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LANES-1:0]    we_lane,
  input  logic [AW-1:0]       waddr,
  input  logic [LANES*LW-1:0] wdata,
  input  logic [AW-1:0]       raddr,
  output logic [LANES*LW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar i = 0; i < LANES; i++) begin : g_bank
    logic [LW-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (we_lane[i]) bank[waddr] <= wdata[i*LW +: LW];
    end

    assign rdata[i*LW +: LW] = bank[raddr];

    // R4
    lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_lane[i]) ##1 $stable(raddr) |-> $stable(rdata[i*LW +: LW]));
  end
endmodule

// File: rtl/bl_async_sram.sv
module bl_async_sram
  import bl_sram_pkg::*;
#(
  parameter int AW       = 10,
  parameter int LANES    = 2,
  parameter int LW       = 8,
  parameter int DUAL_SEL = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_n,
  input  logic                sel_p,
  input  logic                wr_n,
  input  logic                drv_n,
  input  logic [LANES-1:0]    lane_n,
  input  logic [AW-1:0]       addr,
  input  logic [LANES*LW-1:0] wdata,
  output logic [LANES*LW-1:0] rdata,
  output logic [LANES-1:0]    rdata_oe
);
  localparam int DW = LANES * LW;

  sram_mode_e       mode;
  logic [LANES-1:0] drv_lane;
  logic [LANES-1:0] win_lane;
  logic [LANES-1:0] commit;
  logic [AW-1:0]    c_addr;
  logic [DW-1:0]    c_data;
  logic [DW-1:0]    word;

  bl_sram_decode #(.DUAL_SEL(DUAL_SEL), .LANES(LANES)) u_decode (
    .sel_n(sel_n), .sel_p(sel_p), .wr_n(wr_n), .drv_n(drv_n), .lane_n(lane_n),
    .mode(mode), .drv_lane(drv_lane), .win_lane(win_lane)
  );

  bl_sram_wctl #(.AW(AW), .LANES(LANES), .LW(LW)) u_wctl (
    .clk(clk), .rst_n(rst_n), .win_lane(win_lane), .addr(addr), .wdata(wdata),
    .commit(commit), .c_addr(c_addr), .c_data(c_data)
  );

  bl_sram_array #(.AW(AW), .LANES(LANES), .LW(LW)) u_array (
    .clk(clk), .rst_n(rst_n), .we_lane(commit), .waddr(c_addr), .wdata(c_data),
    .raddr(addr), .rdata(word)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_out
    assign rdata[i*LW +: LW] = drv_lane[i] ? word[i*LW +: LW] : '0;
  end
  assign rdata_oe = drv_lane;

  // R1
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n || (DUAL_SEL != 0 && !sel_p)) |-> (rdata_oe == '0));

  // R6
  write_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n) |-> (rdata_oe == '0));

  // R7
  quiet_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_n && wr_n) |-> (rdata_oe == '0));

  // R5
  lane_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdata_oe & lane_n) == '0));

  // R6
  undriven_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_oe == '0) |-> (rdata == '0));
endmodule

// File: tb/test_bl_async_sram.sv
module test_bl_async_sram;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  typedef struct {
    logic [15:0] d_dat;
    logic [1:0]  d_oe;
    logic [15:0] s_dat;
    logic [1:0]  s_oe;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1, sel_p = 1'b1, wr_n = 1'b1, drv_n = 1'b1;
  logic [1:0]  lane_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rd_d, rd_s;
  logic [1:0]  oe_d, oe_s;

  logic [15:0] ref_d [DEPTH];
  logic [15:0] ref_s [DEPTH];
  exp_t        sb_q[$];
  event        sample_ev;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  bl_async_sram #(.AW(AW), .DUAL_SEL(1)) i_bl_async_sram (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel_p(sel_p), .wr_n(wr_n),
    .drv_n(drv_n), .lane_n(lane_n), .addr(addr), .wdata(wdata),
    .rdata(rd_d), .rdata_oe(oe_d));

  bl_async_sram #(.AW(AW), .DUAL_SEL(0)) i_bl_async_sram_single (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel_p(sel_p), .wr_n(wr_n),
    .drv_n(drv_n), .lane_n(lane_n), .addr(addr), .wdata(wdata),
    .rdata(rd_s), .rdata_oe(oe_s));

  function automatic logic [15:0] mask_word(logic [15:0] w, logic [1:0] en);
    return {en[1] ? w[15:8] : 8'h00, en[0] ? w[7:0] : 8'h00};
  endfunction

  function automatic logic [15:0] merge(logic [15:0] old, logic [15:0] nw, logic [1:0] ln);
    return {ln[1] ? old[15:8] : nw[15:8], ln[0] ? old[7:0] : nw[7:0]};
  endfunction

  task automatic push(exp_t e);
    sb_q.push_back(e);
    -> sample_ev;
    #0;
  endtask

  task automatic go_idle();
    sel_n = 1'b1; sel_p = 1'b1; wr_n = 1'b1; drv_n = 1'b1; lane_n = 2'b11;
    wdata = 16'hDEAD;
  endtask

  // called at a falling edge; returns at a falling edge
  task automatic rd(input logic [AW-1:0] a, input logic [1:0] ln, input logic dn,
                    input logic sp, input string tag);
    exp_t e;
    logic [1:0] en_d, en_s;
    sel_n = 1'b0; sel_p = sp; wr_n = 1'b1; drv_n = dn; lane_n = ln; addr = a;
    #1;
    en_d = (sp && !dn) ? ~ln : 2'b00;
    en_s = (!dn) ? ~ln : 2'b00;
    e.d_oe = en_d; e.d_dat = mask_word(ref_d[a], en_d);
    e.s_oe = en_s; e.s_dat = mask_word(ref_s[a], en_s);
    e.tag = tag;
    push(e);
    @(negedge clk);
    go_idle();
  endtask

  // endby: 0 strobe rises, 1 select drops, 2 lane enables rise
  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] ln,
                    input logic dn, input logic sp, input int endby, input string tag);
    exp_t e;
    sel_n = 1'b0; sel_p = sp; wr_n = 1'b0; drv_n = dn; lane_n = ln; addr = a; wdata = d;
    @(negedge clk);
    #1;
    e.d_oe = 2'b00; e.d_dat = 16'h0; e.s_oe = 2'b00; e.s_dat = 16'h0; e.tag = tag;
    push(e);
    @(negedge clk);
    wdata = ~d;
    case (endby)
      0: wr_n = 1'b1;
      1: sel_n = 1'b1;
      default: lane_n = 2'b11;
    endcase
    @(negedge clk);
    go_idle();
    if (sp) ref_d[a] = merge(ref_d[a], d, ln);
    ref_s[a] = merge(ref_s[a], d, ln);
  endtask

  // monitor: pops and compares
  initial begin
    forever begin
      @(sample_ev);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_cmp++;
        if (rd_d !== e.d_dat || oe_d !== e.d_oe || rd_s !== e.s_dat || oe_s !== e.s_oe) begin
          n_bad++;
          $display("FAIL %s: dual %h/%b single %h/%b, expected dual %h/%b single %h/%b",
                   e.tag, rd_d, oe_d, rd_s, oe_s, e.d_dat, e.d_oe, e.s_dat, e.s_oe);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung, expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    exp_t e;
    repeat (3) @(negedge clk);
    // R9: reset state
    #1;
    e.d_oe = 2'b00; e.d_dat = 16'h0; e.s_oe = 2'b00; e.s_dat = 16'h0; e.tag = "R9 reset idle";
    push(e);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 R6 R8 R10: full write ended by strobe, read one cycle later
    wr(10'd5, 16'hA55A, 2'b00, 1'b1, 1'b1, 0, "R6 hiz during write");
    rd(10'd5, 2'b00, 1'b0, 1'b1, "R3 R10 full write readback");
    // R3: drv_n low during write does not matter
    wr(10'd6, 16'h3C96, 2'b00, 1'b0, 1'b1, 0, "R6 hiz with drv low");
    rd(10'd6, 2'b00, 1'b0, 1'b1, "R3 drv ignored on write");
    // R4: lower only, upper only
    wr(10'd5, 16'h11FF, 2'b10, 1'b1, 1'b1, 0, "R6 hiz lower write");
    rd(10'd5, 2'b00, 1'b0, 1'b1, "R4 lower lane only");
    // R8: ended by select drop
    wr(10'd5, 16'h7E00, 2'b01, 1'b1, 1'b1, 1, "R6 hiz upper write");
    rd(10'd5, 2'b00, 1'b0, 1'b1, "R4 R8 upper lane, closed by select");
    // R8: ended by lane enables
    wr(10'd6, 16'hC0DE, 2'b00, 1'b1, 1'b1, 2, "R6 hiz lane-ended write");
    rd(10'd6, 2'b00, 1'b0, 1'b1, "R8 closed by lane enables");
    // R5: partial reads
    rd(10'd6, 2'b10, 1'b0, 1'b1, "R5 read lower lane");
    rd(10'd6, 2'b01, 1'b0, 1'b1, "R5 read upper lane");
    rd(10'd6, 2'b11, 1'b0, 1'b1, "R6 no lane enabled");
    // R7: quiet mode with lanes low and data moving
    sel_n = 1'b0; sel_p = 1'b1; wr_n = 1'b1; drv_n = 1'b1; lane_n = 2'b00;
    addr = 10'd5; wdata = 16'hFFFF;
    @(negedge clk);
    wdata = 16'h0000;
    #1;
    e.d_oe = 2'b00; e.d_dat = 16'h0; e.s_oe = 2'b00; e.s_dat = 16'h0; e.tag = "R7 quiet drives nothing";
    push(e);
    @(negedge clk);
    go_idle();
    @(negedge clk);
    rd(10'd5, 2'b00, 1'b0, 1'b1, "R7 quiet leaves memory");
    // R1 R2: deselected dual vs single
    wr(10'd7, 16'h0BAD, 2'b00, 1'b1, 1'b1, 0, "R6 hiz prefill");
    wr(10'd7, 16'h1234, 2'b00, 1'b1, 1'b0, 0, "R6 hiz sel_p low write");
    rd(10'd7, 2'b00, 1'b0, 1'b0, "R1 R2 read with sel_p low");
    rd(10'd7, 2'b00, 1'b0, 1'b1, "R1 R2 deselected write ignored by dual");
    // R8: split lane close, data changes between closes
    sel_n = 1'b0; sel_p = 1'b1; wr_n = 1'b0; drv_n = 1'b1; lane_n = 2'b00;
    addr = 10'd9; wdata = 16'hAB12;
    @(negedge clk);
    lane_n = 2'b10; wdata = 16'h5634;
    @(negedge clk);
    @(negedge clk);
    wr_n = 1'b1; wdata = 16'hFFFF;
    @(negedge clk);
    go_idle();
    ref_d[9] = 16'hAB34; ref_s[9] = 16'hAB34;
    rd(10'd9, 2'b00, 1'b0, 1'b1, "R8 lanes close separately");
    // boundary addresses
    wr(10'd0, 16'h0F0F, 2'b00, 1'b1, 1'b1, 0, "R6 hiz addr0");
    wr(10'(DEPTH-1), 16'hF00F, 2'b00, 1'b1, 1'b1, 1, "R6 hiz top addr");
    rd(10'd0, 2'b00, 1'b0, 1'b1, "R3 lowest address");
    rd(10'(DEPTH-1), 2'b00, 1'b0, 1'b1, "R3 highest address");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule